// File: doc/BRIEF.md
# Frame-synced serial DAC word receiver

This block is the digital front end of a serial-loaded converter. It takes 16-bit command words from a four-wire port: an active-low chip select, a frame strobe, a serial clock and a data line. All four pins pass through synchronizers clocked by a faster system clock, so the block is fully synchronous. The system clock must run at least four times faster than the serial clock.

A frame starts when the frame strobe falls while chip select is already low. The block then counts serial-clock falling edges and shifts in one data bit on each, most significant bit first. Once all sixteen bits are in, it loads the word into its output latch. The load happens on the next serial-clock rising edge, or earlier if the frame strobe rises first. From the loaded word it takes a 10-bit converter code, a fast/slow settling select and a power-down request. It also emits a one-cycle update pulse.

A frame cut short by chip select or the frame strobe is thrown away. The asynchronous power-on reset clears the shift register, the bit counter and the output latch.

Top module: `sdac_word_rx`

## Requirements
- R1: After reset, dac_code is 0, fast_mode is 0, power_down is 0 and update_pulse is low.
- R2: A frame starts only on a frame-strobe falling edge seen while chip select is low. A strobe that falls while chip select is high, followed by chip select going low and sixteen clocks, loads nothing.
- R3: Bits are taken on serial-clock falling edges, most significant first, with word bit 15 arriving first.
- R4: On a normal frame the latch loads on the first serial-clock rising edge after the sixteenth falling edge, and not before that edge.
- R5: If the frame strobe rises after the sixteenth falling edge and before any later rising serial-clock edge, the latch loads on that strobe edge.
- R6: If chip select or the frame strobe rises before sixteen bits are in, the partial frame is discarded. dac_code, fast_mode and power_down keep their values and no update pulse occurs.
- R7: While chip select is high, activity on the serial clock, data and frame strobe changes nothing at the outputs.
- R8: Word bits 11 down to 2 become dac_code, bit 14 drives fast_mode (1 = fast) and bit 13 drives power_down (1 = powered down). Bits 15, 12, 1 and 0 have no effect.
- R9: Each accepted frame produces exactly one update_pulse, one system clock wide, in the same cycle that the new latch values appear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least 4x the serial clock |
| rst_n | input | 1 | Asynchronous active-low power-on reset |
| cs_n | input | 1 | Chip select, active low |
| fs | input | 1 | Frame strobe |
| sclk | input | 1 | Serial clock |
| din | input | 1 | Serial data |
| dac_code | output | 10 | Latched converter code |
| fast_mode | output | 1 | 1 selects fast settling |
| power_down | output | 1 | 1 requests power-down |
| update_pulse | output | 1 | One-cycle pulse on each latch load |

## Verification
A bit counter one step off, or a shift register taking the wrong edge, shows up as a shifted or misaligned dac_code on the next accepted frame. That is visible about four system cycles after the loading edge. A wrong frame or select state shows up as a missing or extra update pulse: a partial or deselected frame would load, or a full frame would fail to load. The bench therefore checks the pulse count and all three latched fields after every frame. It also checks the pulse count between the sixteenth falling edge and the loading edge, which catches a load that comes too early.

// File: rtl/sdac_pkg.sv
package sdac_pkg;
   localparam int PIN_CS   = 0;
   localparam int PIN_FS   = 1;
   localparam int PIN_SCLK = 2;
   localparam int PIN_DIN  = 3;
   localparam int PIN_N    = 4;
   // idle levels: deselected, strobe high, clock high, data low
   localparam logic [PIN_N-1:0] PIN_IDLE = 4'b0111;

   typedef struct packed {
      logic fast;
      logic pd;
   } sdac_mode_t;
endpackage

// File: rtl/sdac_pin_sync.sv
module sdac_pin_sync #(
   parameter int N = 4,
   parameter int STAGES = 2,
   parameter logic [N-1:0] RST_VAL = '0
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [N-1:0] pin_i,
   output logic [N-1:0] lvl_o
);
   generate
      if (STAGES < 2) begin : g_bad_stages
         $error("sdac_pin_sync needs at least two stages");
      end
      for (genvar i = 0; i < N; i++) begin : g_pin
         logic [STAGES-1:0] chain;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) chain <= {STAGES{RST_VAL[i]}};
            else        chain <= {chain[STAGES-2:0], pin_i[i]};
         end
         assign lvl_o[i] = chain[STAGES-1];
      end
   endgenerate
endmodule

// File: rtl/sdac_frame_rx.sv
module sdac_frame_rx #(
   parameter int WORD_W = 16,
   parameter bit FS_UPDATE_EN = 1'b1,
   localparam int CNT_W = $clog2(WORD_W + 1)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cs_lvl,
   input  logic              fs_lvl,
   input  logic              sclk_lvl,
   input  logic              din_lvl,
   output logic              commit_o,
   output logic [WORD_W-1:0] word_o
);
   localparam logic [CNT_W-1:0] FULL = CNT_W'(WORD_W);

   logic             fs_prev, sclk_prev;
   logic             fs_rise, fs_fall, sclk_rise, sclk_fall;
   logic             in_frame;
   logic [CNT_W-1:0] cnt;
   logic             fs_done_ok;

   assign fs_rise   =  fs_lvl   & ~fs_prev;
   assign fs_fall   = ~fs_lvl   &  fs_prev;
   assign sclk_rise =  sclk_lvl & ~sclk_prev;
   assign sclk_fall = ~sclk_lvl &  sclk_prev;

   generate
      if (WORD_W < 2) begin : g_bad_word
         $error("sdac_frame_rx word too short");
      end
      if (FS_UPDATE_EN) begin : g_fs_load
         assign fs_done_ok = (cnt == FULL);
      end else begin : g_fs_abort
         assign fs_done_ok = 1'b0;
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         fs_prev   <= 1'b1;
         sclk_prev <= 1'b1;
         in_frame  <= 1'b0;
         cnt       <= '0;
         word_o    <= '0;
         commit_o  <= 1'b0;
      end else begin
         fs_prev   <= fs_lvl;
         sclk_prev <= sclk_lvl;
         commit_o  <= 1'b0;
         if (cs_lvl) begin
            in_frame <= 1'b0;
         end else if (fs_fall) begin
            in_frame <= 1'b1;
            cnt      <= '0;
         end else if (in_frame) begin
            if (fs_rise) begin
               commit_o <= fs_done_ok;
               in_frame <= 1'b0;
            end else if (sclk_fall && cnt < FULL) begin
               word_o <= {word_o[WORD_W-2:0], din_lvl};
               cnt    <= cnt + 1'b1;
            end else if (sclk_rise && cnt == FULL) begin
               commit_o <= 1'b1;
               in_frame <= 1'b0;
            end
         end
      end
   end

   assert_cnt_bound_R3: assert property (@(posedge clk) disable iff (!rst_n)
      cnt <= FULL);
   assert_deselect_idle_R7: assert property (@(posedge clk) disable iff (!rst_n)
      cs_lvl |=> !in_frame && !commit_o);
   assert_commit_full_R6: assert property (@(posedge clk) disable iff (!rst_n)
      commit_o |-> $past(cnt) == FULL && $past(in_frame));
endmodule

// File: rtl/sdac_out_latch.sv
module sdac_out_latch
   import sdac_pkg::*;
#(
   parameter int WORD_W = 16,
   parameter int CODE_W = 10,
   parameter int CODE_LSB = 2,
   parameter int PD_BIT = 13,
   parameter int FAST_BIT = 14
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              commit_i,
   input  logic [WORD_W-1:0] word_i,
   output logic [CODE_W-1:0] code_o,
   output sdac_mode_t        mode_o,
   output logic              pulse_o
);
   localparam logic [WORD_W-1:0] USED_MASK =
      (((WORD_W'(1) << CODE_W) - 1'b1) << CODE_LSB) |
      (WORD_W'(1) << PD_BIT) | (WORD_W'(1) << FAST_BIT);

   generate
      if (CODE_LSB + CODE_W > WORD_W || PD_BIT >= WORD_W || FAST_BIT >= WORD_W)
      begin : g_bad_layout
         $error("sdac_out_latch field outside the word");
      end
   endgenerate

   logic unused_bits;
   assign unused_bits = ^(word_i & ~USED_MASK);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         code_o  <= '0;
         mode_o  <= '0;
         pulse_o <= 1'b0;
      end else begin
         pulse_o <= commit_i;
         if (commit_i) begin
            code_o      <= word_i[CODE_LSB +: CODE_W];
            mode_o.fast <= word_i[FAST_BIT];
            mode_o.pd   <= word_i[PD_BIT];
         end
      end
   end

   assert_pulse_width_R9: assert property (@(posedge clk) disable iff (!rst_n)
      pulse_o |=> !pulse_o);
   assert_hold_between_R6: assert property (@(posedge clk) disable iff (!rst_n)
      !pulse_o |-> $stable(code_o) && $stable(mode_o));
endmodule

// File: rtl/sdac_word_rx.sv
module sdac_word_rx
   import sdac_pkg::*;
#(
   parameter int WORD_W = 16,
   parameter int CODE_W = 10,
   parameter int CODE_LSB = 2,
   parameter int PD_BIT = 13,
   parameter int FAST_BIT = 14,
   parameter int SYNC_STAGES = 2,
   parameter bit FS_UPDATE_EN = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cs_n,
   input  logic              fs,
   input  logic              sclk,
   input  logic              din,
   output logic [CODE_W-1:0] dac_code,
   output logic              fast_mode,
   output logic              power_down,
   output logic              update_pulse
);
   logic [PIN_N-1:0]  pins, lvl;
   logic              commit;
   logic [WORD_W-1:0] word;
   sdac_mode_t        mode;

   assign pins[PIN_CS]   = cs_n;
   assign pins[PIN_FS]   = fs;
   assign pins[PIN_SCLK] = sclk;
   assign pins[PIN_DIN]  = din;

   sdac_pin_sync #(.N(PIN_N), .STAGES(SYNC_STAGES), .RST_VAL(PIN_IDLE)) u_sync (
      .clk(clk), .rst_n(rst_n), .pin_i(pins), .lvl_o(lvl));

   sdac_frame_rx #(.WORD_W(WORD_W), .FS_UPDATE_EN(FS_UPDATE_EN)) u_frame (
      .clk(clk), .rst_n(rst_n),
      .cs_lvl(lvl[PIN_CS]), .fs_lvl(lvl[PIN_FS]),
      .sclk_lvl(lvl[PIN_SCLK]), .din_lvl(lvl[PIN_DIN]),
      .commit_o(commit), .word_o(word));

   sdac_out_latch #(.WORD_W(WORD_W), .CODE_W(CODE_W), .CODE_LSB(CODE_LSB),
                    .PD_BIT(PD_BIT), .FAST_BIT(FAST_BIT)) u_latch (
      .clk(clk), .rst_n(rst_n), .commit_i(commit), .word_i(word),
      .code_o(dac_code), .mode_o(mode), .pulse_o(update_pulse));

   assign fast_mode  = mode.fast;
   assign power_down = mode.pd;

   assert_reset_clear_R1: assert property (@(posedge clk)
      !rst_n |=> dac_code == '0 && !update_pulse);
endmodule

// File: tb/sdac_word_rx_test.sv
module sdac_word_rx_test;
   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic cs_n = 1'b1, fs = 1'b1, sclk = 1'b1, din = 1'b0;
   logic [9:0] dac_code;
   logic fast_mode, power_down, update_pulse;

   int vectors = 0, miscompares = 0, pulses = 0;
   logic [9:0] exp_code = '0;
   logic exp_fast = 1'b0, exp_pd = 1'b0;

   always #2.5 clk = ~clk;

   sdac_word_rx uut (.clk(clk), .rst_n(rst_n), .cs_n(cs_n), .fs(fs), .sclk(sclk),
      .din(din), .dac_code(dac_code), .fast_mode(fast_mode),
      .power_down(power_down), .update_pulse(update_pulse));

   always @(posedge clk) if (update_pulse) pulses <= pulses + 1;

   task automatic wt(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
      vectors++;
      if (act !== exp) begin
         miscompares++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   // mode: 0 normal, 1 strobe-end, 2 select abort, 3 strobe abort,
   //       4 deselected, 5 strobe fell before select
   task automatic send(input logic [15:0] w, input int nb, input int mode, input string tag);
      int p0 = pulses;
      int nfall = (mode == 2 || mode == 3) ? nb : 16;
      cs_n = (mode == 4 || mode == 5);
      wt(4); fs = 1'b0; wt(4);
      if (mode == 5) cs_n = 1'b0;
      wt(4);
      for (int i = 0; i < nfall; i++) begin
         din = w[15-i]; wt(4); sclk = 1'b0;
         if (i == 15) begin
            wt(8);
            check({tag, " R4 no load before edge"}, 16'(pulses - p0), 16'd0);
         end else wt(4);
         if (!(mode == 1 && i == 15)) sclk = 1'b1;
      end
      case (mode)
         1: begin fs = 1'b1; wt(4); sclk = 1'b1; end
         2: begin cs_n = 1'b1; wt(4); fs = 1'b1; end
         default: begin wt(4); fs = 1'b1; end
      endcase
      wt(10); cs_n = 1'b1; wt(6);
      if (mode <= 1) begin
         exp_code = w[11:2]; exp_fast = w[14]; exp_pd = w[13];
      end
      check(tag, {2'(pulses - p0), 2'b0, power_down, fast_mode, dac_code},
            {(mode <= 1) ? 2'd1 : 2'd0, 2'b0, exp_pd, exp_fast, exp_code});
   endtask

   initial begin
      wt(5);
      check("R1 reset", {3'b0, update_pulse, 1'b0, power_down, fast_mode, dac_code}, 16'h0);
      rst_n = 1'b1; wt(5);
      check("R1 after release", {3'b0, update_pulse, 1'b0, power_down, fast_mode, dac_code}, 16'h0);
      send(16'h6FFF, 16, 0, "R8 full code fast pd");
      send(16'h0000, 16, 1, "R5 zero by strobe");
      send(16'h9003, 16, 0, "R8 reserved bits ignored");
      send(16'h4AA8, 16, 0, "R3 pattern");
      send(16'h2554, 10, 2, "R6 select abort");
      send(16'h2554, 15, 3, "R6 strobe abort");
      send(16'h2554, 16, 4, "R7 deselected");
      send(16'h2554, 16, 5, "R2 strobe before select");
      for (int k = 0; k < 256; k++) begin
         logic [9:0] c = 10'((k * 4 + (k >> 6)) & 1023);
         logic [15:0] w = {4'(k), c, 2'(k >> 4)};
         send(w, 16, (k >> 6) & 1, "R3 R9 sweep");
      end
      send(16'h6FFC, 16, 1, "R5 R9 full by strobe");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
   end

   initial begin
      wt(190000);
      miscompares++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
   end
endmodule